// File: doc/BRIEF.md
# CAS Latency Read/Write Data Pipeline

This block is the data path that sits between a synchronous DRAM array and its 32-bit data bus. It can serve a device model or the matching path in a controller. A read beat takes the word that the array presents in the same cycle and shows it on the read bus after the selected CAS latency of one, two or three cycles. A write beat passes the bus word to the array in the same cycle, together with per-byte write strobes.

The byte mask inputs act on the two directions with different timing. On a write, a mask bit blocks its byte lane on the same edge. On a read, a mask bit turns its lane's output enable off two edges later, whatever latency is selected.

A small burst tracker follows the column stream. A read or write command opens a burst, and each following cycle that is marked column-valid becomes a beat of that burst. A burst-stop or precharge strobe closes the burst at once. Data already in the read pipeline still drains, so output lasts for latency-minus-one further cycles.

Top module: `sdr_data_pipe`

## Requirements
- R1: After reset, with idle inputs, `rd_oe_o` is 0, `rd_data_o` is 0 and `wr_be_o` is 0.
- R2: A read beat sampled at edge E with `cl_sel_i` = N (1, 2 or 3) places the array word of that cycle on `rd_data_o`, with all four bits of `rd_oe_o` set, for sampling at edge E+N only. Code 0 behaves as latency 1.
- R3: Read beats on consecutive cycles, one new column per cycle, appear on consecutive output cycles with no gap.
- R4: `dqm_i[b]` high at edge E clears `rd_oe_o[b]` and zeroes byte b (bits 8b+7..8b) of `rd_data_o` for sampling at edge E+2, for every latency, and leaves the other lanes alone. A lane whose enable is low always reads as zero.
- R5: During a write beat, `wr_be_o[b]` equals the inverse of `dqm_i[b]` in the same cycle, and `wr_data_o` equals `wr_data_i`.
- R6: A burst-stop strobe at edge E suppresses the beat at E and every later beat of that burst. Read output continues for exactly N-1 further sampling edges (E+1 .. E+N-1) and then goes to zero.
- R7: A precharge strobe ends a burst exactly as a burst stop does.
- R8: A column-valid cycle outside an open burst produces no write strobe and no read output.
- R9: A new read or write command ends the current burst and starts one in its own direction. If both commands arrive together, the read wins and no write strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low reset |
| cl_sel_i | input | 2 | Read latency select: 1, 2 or 3 cycles (0 acts as 1) |
| rd_cmd_i | input | 1 | Decoded read command |
| wr_cmd_i | input | 1 | Decoded write command |
| stop_i | input | 1 | Decoded burst-stop command |
| pre_i | input | 1 | Decoded precharge of the bank in burst |
| beat_vld_i | input | 1 | Column data valid this cycle |
| dqm_i | input | 4 | Per-byte mask, bit b covers byte b |
| wr_data_i | input | 32 | Write data from the bus |
| arr_rd_data_i | input | 32 | Word read from the array this cycle |
| rd_data_o | output | 32 | Read data to the bus, masked lanes zero |
| rd_oe_o | output | 4 | Per-byte output enable (low means high impedance) |
| wr_data_o | output | 32 | Write data to the array |
| wr_be_o | output | 4 | Per-byte write strobes to the array |

## Verification
The hardest case to reach is a read burst that is cut short while beats are still in the pipeline. To show that exactly latency-minus-one words drain and nothing more, the stimulus keeps the column-valid input high through the stop cycle and beyond. The stop is placed at a fixed offset inside a running burst and repeated at each latency, with a precharge variant. Read masking is checked with a mask pulse that falls on a different beat than the one it hides. A second mask pulse arrives after the burst has ended but while its last word is still in flight. Both are run at latency three and at latency one, so the two-cycle mask timing can be seen apart from the data timing.

// File: rtl/sdr_pipe_pkg.sv
// Shared definitions for the CAS latency data pipeline.
// Assumes byte lanes of eight bits on the data bus.
package sdr_pipe_pkg;

    localparam int BYTE_W = 8;

    // Direction of the open burst.
    typedef enum logic {
        DIR_RD = 1'b0,
        DIR_WR = 1'b1
    } burst_dir_e;

endpackage

// File: rtl/sdr_burst_ctl.sv
// Burst tracker: turns the decoded command strobes and the column-valid
// stream into read and write beats.
// Assumes at most one of read/write is meant per cycle; a read wins a tie.
// A stop or precharge closes the burst and suppresses the beat of its own cycle.
module sdr_burst_ctl
    import sdr_pipe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_cmd_i,
    input  logic wr_cmd_i,
    input  logic stop_i,
    input  logic pre_i,
    input  logic beat_vld_i,
    output logic rd_beat_o,
    output logic wr_beat_o
);

    logic       open_q, open_d;
    burst_dir_e dir_q, dir_d;

    // Decide this cycle's beat and the next burst state.
    always_comb begin
        rd_beat_o = 1'b0;
        wr_beat_o = 1'b0;
        open_d    = open_q;
        dir_d     = dir_q;
        if (rd_cmd_i) begin
            open_d    = 1'b1;
            dir_d     = DIR_RD;
            rd_beat_o = beat_vld_i;
        end else if (wr_cmd_i) begin
            open_d    = 1'b1;
            dir_d     = DIR_WR;
            wr_beat_o = beat_vld_i;
        end else if (stop_i || pre_i) begin
            open_d    = 1'b0;
        end else if (open_q) begin
            rd_beat_o = beat_vld_i && (dir_q == DIR_RD);
            wr_beat_o = beat_vld_i && (dir_q == DIR_WR);
        end
    end

    // Hold the burst state between cycles.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            dir_q  <= DIR_RD;
        end else begin
            open_q <= open_d;
            dir_q  <= dir_d;
        end
    end

endmodule

// File: rtl/sdr_rd_pipe.sv
// Read latency pipeline: a shift register MAX_CL stages deep that carries
// a valid flag and the array word, tapped at the selected latency.
// Assumes lat_i holds its value while a burst drains; a latency of zero or
// above MAX_CL taps nothing.
module sdr_rd_pipe #(
    parameter int DATA_W = 32,
    parameter int MAX_CL = 3,
    parameter int CL_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld_i,
    input  logic [DATA_W-1:0] in_data_i,
    input  logic [CL_W-1:0]   lat_i,
    output logic              out_vld_o,
    output logic [DATA_W-1:0] out_data_o
);

    logic [MAX_CL-1:0]             stg_vld_q;
    logic [MAX_CL-1:0][DATA_W-1:0] stg_dat_q;

    // Shift each beat one stage per clock.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_vld_q <= '0;
            stg_dat_q <= '0;
        end else begin
            stg_vld_q[0] <= in_vld_i;
            stg_dat_q[0] <= in_data_i;
            for (int i = 1; i < MAX_CL; i++) begin
                stg_vld_q[i] <= stg_vld_q[i-1];
                stg_dat_q[i] <= stg_dat_q[i-1];
            end
        end
    end

    // Pick the stage that matches the selected latency.
    always_comb begin
        out_vld_o  = 1'b0;
        out_data_o = '0;
        for (int i = 0; i < MAX_CL; i++) begin
            if (lat_i == CL_W'(i + 1)) begin
                out_vld_o  = stg_vld_q[i];
                out_data_o = stg_dat_q[i];
            end
        end
    end

endmodule

// File: rtl/sdr_dqm_ctl.sv
// Byte mask timing. Read masks pass through a delay line RD_DQM_LAT deep,
// so the mask is independent of the read latency. Write masks apply at once.
// Assumes RD_DQM_LAT is at least one.
module sdr_dqm_ctl #(
    parameter int LANES      = 4,
    parameter int RD_DQM_LAT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] dqm_i,
    input  logic             wr_beat_i,
    output logic [LANES-1:0] rd_mask_o,
    output logic [LANES-1:0] wr_be_o
);

    logic [RD_DQM_LAT-1:0][LANES-1:0] mask_q;

    // Delay the sampled mask for the read direction.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            mask_q[0] <= dqm_i;
            for (int i = 1; i < RD_DQM_LAT; i++) begin
                mask_q[i] <= mask_q[i-1];
            end
        end
    end

    // Present the delayed read mask.
    always_comb rd_mask_o = mask_q[RD_DQM_LAT-1];

    // Write strobes: lanes of a write beat not blocked by this cycle's mask.
    always_comb wr_be_o = {LANES{wr_beat_i}} & ~dqm_i;

endmodule

// File: rtl/sdr_data_pipe.sv
// Top of the CAS latency data pipeline. Links the burst tracker, the read
// latency pipeline and the byte mask timing, and gates read lanes to zero
// when their enable is low.
// Assumes DATA_W is a multiple of eight and cl_sel_i is held steady across
// a burst and its drain.
module sdr_data_pipe #(
    parameter int DATA_W     = 32,
    parameter int MAX_CL     = 3,
    parameter int RD_DQM_LAT = 2,
    parameter int CL_W       = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [CL_W-1:0]                    cl_sel_i,
    input  logic                               rd_cmd_i,
    input  logic                               wr_cmd_i,
    input  logic                               stop_i,
    input  logic                               pre_i,
    input  logic                               beat_vld_i,
    input  logic [DATA_W/sdr_pipe_pkg::BYTE_W-1:0] dqm_i,
    input  logic [DATA_W-1:0]                  wr_data_i,
    input  logic [DATA_W-1:0]                  arr_rd_data_i,
    output logic [DATA_W-1:0]                  rd_data_o,
    output logic [DATA_W/sdr_pipe_pkg::BYTE_W-1:0] rd_oe_o,
    output logic [DATA_W-1:0]                  wr_data_o,
    output logic [DATA_W/sdr_pipe_pkg::BYTE_W-1:0] wr_be_o
);
    import sdr_pipe_pkg::*;

    localparam int LANES = DATA_W / BYTE_W;

    logic              rd_beat, wr_beat;
    logic [CL_W-1:0]   lat_eff;
    logic              tap_vld;
    logic [DATA_W-1:0] tap_data;
    logic [LANES-1:0]  rd_mask;

    // Map the reserved latency code zero onto one cycle.
    always_comb lat_eff = (cl_sel_i == '0) ? CL_W'(1) : cl_sel_i;

    sdr_burst_ctl u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_cmd_i   (rd_cmd_i),
        .wr_cmd_i   (wr_cmd_i),
        .stop_i     (stop_i),
        .pre_i      (pre_i),
        .beat_vld_i (beat_vld_i),
        .rd_beat_o  (rd_beat),
        .wr_beat_o  (wr_beat)
    );

    sdr_rd_pipe #(
        .DATA_W (DATA_W),
        .MAX_CL (MAX_CL),
        .CL_W   (CL_W)
    ) u_rd_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_vld_i   (rd_beat),
        .in_data_i  (arr_rd_data_i),
        .lat_i      (lat_eff),
        .out_vld_o  (tap_vld),
        .out_data_o (tap_data)
    );

    sdr_dqm_ctl #(
        .LANES      (LANES),
        .RD_DQM_LAT (RD_DQM_LAT)
    ) u_dqm (
        .clk       (clk),
        .rst_n     (rst_n),
        .dqm_i     (dqm_i),
        .wr_beat_i (wr_beat),
        .rd_mask_o (rd_mask),
        .wr_be_o   (wr_be_o)
    );

    // Output enable per lane: valid tapped word and lane not masked.
    always_comb rd_oe_o = {LANES{tap_vld}} & ~rd_mask;

    // Write data goes straight to the array; strobes qualify it.
    always_comb wr_data_o = wr_data_i;

    // Drive zero on every lane whose enable is low.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign rd_data_o[g*BYTE_W +: BYTE_W] =
            rd_oe_o[g] ? tap_data[g*BYTE_W +: BYTE_W] : '0;
    end

endmodule

// File: rtl/sdr_data_pipe_chk.sv
// Checker for the CAS latency data pipeline, bound to the top module.
// Relates port values across cycles; holds no copy of the datapath.
module sdr_data_pipe_chk #(
    parameter int DATA_W = 32,
    parameter int CL_W   = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [CL_W-1:0]         cl_sel_i,
    input logic                    rd_cmd_i,
    input logic                    wr_cmd_i,
    input logic                    stop_i,
    input logic                    pre_i,
    input logic                    beat_vld_i,
    input logic [DATA_W/8-1:0]     dqm_i,
    input logic [DATA_W-1:0]       rd_data_o,
    input logic [DATA_W/8-1:0]     rd_oe_o,
    input logic [DATA_W/8-1:0]     wr_be_o
);
    localparam int LANES = DATA_W / 8;

    logic [1:0] warm_q;

    // Count edges since reset so that $past looks only at cycles after it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              warm_q <= 2'd0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    for (genvar b = 0; b < LANES; b++) begin : g_lane_chk
        // R4: a read mask acts two edges after it is sampled.
        p_rd_mask_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (warm_q >= 2'd2 && $past(dqm_i[b], 2)) |-> !rd_oe_o[b]);
        // R4: a disabled lane reads as zero.
        p_lane_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_oe_o[b] |-> (rd_data_o[b*8 +: 8] == 8'h00));
    end

    // R5: no strobe on a lane that is masked in the same cycle.
    p_wr_mask_now_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_be_o & dqm_i) == '0);

    // R8: a write strobe needs a valid column in the same cycle.
    p_strobe_needs_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_be_o != '0) |-> beat_vld_i);

    // R6: at latency one a stop leaves nothing to drain.
    p_stop_drain_cl1_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((stop_i || pre_i) && !rd_cmd_i && !wr_cmd_i && cl_sel_i == CL_W'(1))
        |=> (cl_sel_i != CL_W'(1) || rd_oe_o == '0));

    // R7: a precharge leaves no write strobe in its cycle.
    p_pre_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_i && !rd_cmd_i && !wr_cmd_i) |-> (wr_be_o == '0));

    // R9: a read command blocks every write strobe.
    p_read_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cmd_i |-> (wr_be_o == '0));

endmodule

bind sdr_data_pipe sdr_data_pipe_chk #(
    .DATA_W (DATA_W),
    .CL_W   (CL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cl_sel_i   (cl_sel_i),
    .rd_cmd_i   (rd_cmd_i),
    .wr_cmd_i   (wr_cmd_i),
    .stop_i     (stop_i),
    .pre_i      (pre_i),
    .beat_vld_i (beat_vld_i),
    .dqm_i      (dqm_i),
    .rd_data_o  (rd_data_o),
    .rd_oe_o    (rd_oe_o),
    .wr_be_o    (wr_be_o)
);

// File: tb/tb_sdr_data_pipe.sv
// Directed bench for the CAS latency data pipeline. Inputs change on the
// falling edge; registered outputs are checked on the falling edge before
// new inputs are applied, and write strobes shortly after them.
module tb_sdr_data_pipe;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cl_sel_i = 2'd1;
    logic        rd_cmd_i = 1'b0, wr_cmd_i = 1'b0, stop_i = 1'b0, pre_i = 1'b0;
    logic        beat_vld_i = 1'b0;
    logic [3:0]  dqm_i = 4'h0;
    logic [31:0] wr_data_i = '0, arr_rd_data_i = '0;
    logic [31:0] rd_data_o, wr_data_o;
    logic [3:0]  rd_oe_o, wr_be_o;

    int checks = 0;
    int errors = 0;

    // Stimulus and expectation tables indexed by cycle of a scenario.
    logic        st_rd [NS], st_wr [NS], st_stop [NS], st_pre [NS], st_vld [NS];
    logic [3:0]  st_dqm [NS];
    logic [31:0] st_wd [NS], st_arr [NS];
    logic [3:0]  ex_oe [NS], ex_be [NS];
    logic [31:0] ex_dat [NS];
    logic        be_chk [NS];

    sdr_data_pipe dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cl_sel_i      (cl_sel_i),
        .rd_cmd_i      (rd_cmd_i),
        .wr_cmd_i      (wr_cmd_i),
        .stop_i        (stop_i),
        .pre_i         (pre_i),
        .beat_vld_i    (beat_vld_i),
        .dqm_i         (dqm_i),
        .wr_data_i     (wr_data_i),
        .arr_rd_data_i (arr_rd_data_i),
        .rd_data_o     (rd_data_o),
        .rd_oe_o       (rd_oe_o),
        .wr_data_o     (wr_data_o),
        .wr_be_o       (wr_be_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] lane_gate(input logic [31:0] d, input logic [3:0] oe);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) r[b*8 +: 8] = oe[b] ? d[b*8 +: 8] : 8'h00;
        return r;
    endfunction

    task automatic check_rd(input string req, input int k, input logic [3:0] oe, input logic [31:0] d);
        checks++;
        if (rd_oe_o !== oe || rd_data_o !== lane_gate(d, oe)) begin
            errors++;
            $display("FAIL %s cycle %0d: oe=%b data=%h expected oe=%b data=%h",
                     req, k, rd_oe_o, rd_data_o, oe, lane_gate(d, oe));
        end
    endtask

    task automatic check_wr(input string req, input int k, input logic [3:0] be, input logic [31:0] d);
        checks++;
        if (wr_be_o !== be || wr_data_o !== d) begin
            errors++;
            $display("FAIL %s cycle %0d: be=%b wdata=%h expected be=%b wdata=%h",
                     req, k, wr_be_o, wr_data_o, be, d);
        end
    endtask

    task automatic drive_idle();
        rd_cmd_i = 0; wr_cmd_i = 0; stop_i = 0; pre_i = 0; beat_vld_i = 0;
        dqm_i = 4'h0; wr_data_i = '0; arr_rd_data_i = '0;
    endtask

    task automatic clr();
        for (int i = 0; i < NS; i++) begin
            st_rd[i] = 0; st_wr[i] = 0; st_stop[i] = 0; st_pre[i] = 0; st_vld[i] = 0;
            st_dqm[i] = 4'h0; st_wd[i] = '0; st_arr[i] = '0;
            ex_oe[i] = 4'h0; ex_be[i] = 4'h0; ex_dat[i] = '0; be_chk[i] = 0;
        end
    endtask

    // Close any burst and let the pipeline drain.
    task automatic quiesce();
        @(negedge clk);
        drive_idle();
        stop_i = 1;
        @(negedge clk);
        stop_i = 0;
        repeat (4) @(negedge clk);
    endtask

    // Play the tables for n cycles and check every cycle.
    task automatic run(input int n, input string req);
        for (int k = 0; k <= n; k++) begin
            @(negedge clk);
            check_rd(req, k, ex_oe[k], ex_dat[k]);
            if (k < n) begin
                rd_cmd_i = st_rd[k]; wr_cmd_i = st_wr[k]; stop_i = st_stop[k];
                pre_i = st_pre[k]; beat_vld_i = st_vld[k]; dqm_i = st_dqm[k];
                wr_data_i = st_wd[k]; arr_rd_data_i = st_arr[k];
            end else begin
                drive_idle();
            end
            #1;
            if (k < n && be_chk[k]) check_wr(req, k, ex_be[k], st_wd[k]);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        checks++;
        if (rd_oe_o !== 4'h0 || rd_data_o !== 32'h0 || wr_be_o !== 4'h0) begin
            errors++;
            $display("FAIL R1: oe=%b data=%h be=%b expected all zero", rd_oe_o, rd_data_o, wr_be_o);
        end
    endtask

    // R2: first read data appears exactly N cycles after the command.
    task automatic t_latency(input logic [1:0] code, input int n_exp);
        cl_sel_i = code;
        quiesce();
        clr();
        st_rd[0] = 1; st_vld[0] = 1; st_arr[0] = 32'hA5C3_0000 | 32'(code);
        ex_oe[n_exp] = 4'hF; ex_dat[n_exp] = st_arr[0];
        run(5, "R2");
    endtask

    // R3: one new column per cycle gives gapless output.
    task automatic t_back_to_back();
        cl_sel_i = 2'd2;
        quiesce();
        clr();
        st_rd[0] = 1;
        for (int i = 0; i < 4; i++) begin
            st_vld[i] = 1; st_arr[i] = 32'h1111_1111 * (i + 1);
            ex_oe[i+2] = 4'hF; ex_dat[i+2] = st_arr[i];
        end
        run(7, "R3");
    endtask

    // R4 at latency 3: mask on beat 2 hides beat 1's word; mask after burst hides last word.
    task automatic t_rd_mask_cl3();
        cl_sel_i = 2'd3;
        quiesce();
        clr();
        st_rd[0] = 1;
        for (int i = 0; i < 4; i++) begin
            st_vld[i] = 1; st_arr[i] = 32'hC0DE_0000 + 32'(i * 32'h0101_0101);
            ex_oe[i+3] = 4'hF; ex_dat[i+3] = st_arr[i];
        end
        st_dqm[2] = 4'b0101; ex_oe[4] = 4'b1010;
        st_dqm[4] = 4'b1000; ex_oe[6] = 4'b0111;
        run(8, "R4");
    endtask

    // R4 at latency 1: mask still lands two cycles after it is sampled.
    task automatic t_rd_mask_cl1();
        cl_sel_i = 2'd1;
        quiesce();
        clr();
        st_rd[0] = 1;
        for (int i = 0; i < 3; i++) begin
            st_vld[i] = 1; st_arr[i] = 32'hFEED_BEE0 + 32'(i);
            ex_oe[i+1] = 4'hF; ex_dat[i+1] = st_arr[i];
        end
        st_dqm[0] = 4'b0010; ex_oe[2] = 4'b1101;
        run(5, "R4");
    endtask

    // R5: write strobes follow the mask in the same cycle.
    task automatic t_write();
        cl_sel_i = 2'd2;
        quiesce();
        clr();
        st_wr[0] = 1;
        for (int i = 0; i < 4; i++) begin
            st_vld[i] = 1; st_wd[i] = 32'h5A5A_0000 + 32'(i); be_chk[i] = 1;
        end
        st_dqm[0] = 4'h0;    ex_be[0] = 4'hF;
        st_dqm[1] = 4'b0110; ex_be[1] = 4'b1001;
        st_dqm[2] = 4'hF;    ex_be[2] = 4'h0;
        st_dqm[3] = 4'b0001; ex_be[3] = 4'b1110;
        run(6, "R5");
    endtask

    // R6/R7: stop or precharge at cycle 3 of a running read burst.
    task automatic t_cut(input logic [1:0] code, input bit use_pre, input string req);
        cl_sel_i = code;
        quiesce();
        clr();
        st_rd[0] = 1;
        for (int i = 0; i < 6; i++) begin
            st_vld[i] = 1; st_arr[i] = 32'h7700_0000 + 32'(i * 32'h0001_0203);
        end
        if (use_pre) st_pre[3] = 1; else st_stop[3] = 1;
        for (int j = 0; j < 3; j++) begin
            ex_oe[int'(code) + j] = 4'hF; ex_dat[int'(code) + j] = st_arr[j];
        end
        for (int i = 3; i < 6; i++) be_chk[i] = 1;
        run(9, req);
    endtask

    // R8: column-valid cycles with no open burst do nothing.
    task automatic t_idle_beats();
        cl_sel_i = 2'd1;
        quiesce();
        clr();
        for (int i = 0; i < 4; i++) begin
            st_vld[i] = 1; st_wd[i] = 32'hDEAD_0000 + 32'(i);
            st_arr[i] = 32'hBEEF_0000 + 32'(i); be_chk[i] = 1;
        end
        run(6, "R8");
    endtask

    // R9: a write interrupts a read; a tied read/write goes to the read.
    task automatic t_interrupt();
        cl_sel_i = 2'd2;
        quiesce();
        clr();
        st_rd[0] = 1; st_vld[0] = 1; st_arr[0] = 32'h0000_00D0;
        st_vld[1] = 1; st_arr[1] = 32'h0000_00D1;
        st_wr[2] = 1; st_vld[2] = 1; st_wd[2] = 32'h0000_0E02; be_chk[2] = 1; ex_be[2] = 4'hF;
        st_vld[3] = 1; st_wd[3] = 32'h0000_0E03; be_chk[3] = 1; ex_be[3] = 4'hF;
        st_rd[4] = 1; st_wr[4] = 1; st_vld[4] = 1; st_arr[4] = 32'h0000_00D4;
        st_wd[4] = 32'h0000_0E04; be_chk[4] = 1; ex_be[4] = 4'h0;
        st_vld[5] = 1; st_arr[5] = 32'h0000_00D5; st_wd[5] = 32'h0000_0E05;
        be_chk[5] = 1; ex_be[5] = 4'h0;
        ex_oe[2] = 4'hF; ex_dat[2] = st_arr[0];
        ex_oe[3] = 4'hF; ex_dat[3] = st_arr[1];
        ex_oe[6] = 4'hF; ex_dat[6] = st_arr[4];
        ex_oe[7] = 4'hF; ex_dat[7] = st_arr[5];
        run(9, "R9");
    endtask

    initial begin
        drive_idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_latency(2'd1, 1);
        t_latency(2'd2, 2);
        t_latency(2'd3, 3);
        t_latency(2'd0, 1);
        t_back_to_back();
        t_rd_mask_cl3();
        t_rd_mask_cl1();
        t_write();
        t_cut(2'd3, 0, "R6");
        t_cut(2'd2, 0, "R6");
        t_cut(2'd1, 0, "R6");
        t_cut(2'd3, 1, "R7");
        t_idle_beats();
        t_interrupt();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule